// File: doc/BRIEF.md
# Temperature-Scaled Refresh Interval Scheduler

This block sits in a DRAM controller and decides when a refresh is owed. A device needs 8192 refresh commands inside each retention window, and that window shortens as the case gets hotter: 64 ms at 85°C and below, 32 ms from above 85°C to 95°C, and 16 ms above 95°C. The scheduler divides the current window by 8192 to get a per-refresh interval in clock cycles. It counts that interval down and adds one owed refresh each time the count expires.

Temperature arrives as a signed value in whole degrees Celsius, qualified by a valid strobe. A move into a hotter band shortens the interval currently running at once. A move into a cooler band waits until the running interval ends. The command arbiter sees a level request while any refresh is owed. Each acknowledge retires one owed refresh. The owed count is capped, so a long stall cannot build up an unbounded backlog. A sample above 105°C raises an error flag and keeps the shortest interval.

Top module: `refresh_scheduler`

## Requirements
- R1: After reset, ref_req_o is 0, postponed_o is 0 and over_temp_o is 0. The 64 ms band is in force, so the first request appears exactly IVL0 rising edges after reset is released.
- R2: A sample with temp_vld_i high selects the band. At or below 85 the band is cool. From 86 to 95 it is warm. Above 95 it is hot. The value is signed 8-bit degrees Celsius.
- R3: The interval is IVL0 = floor(CYC_PER_US*15625/2000) cycles in the cool band, IVL0/2 in the warm band and IVL0/4 in the hot band (integer division). Each expiry adds one owed refresh.
- R4: When the sampled band is hotter than the band in force, the hotter band takes over on the next edge. The remaining count becomes the smaller of the decremented count and the new interval minus one.
- R5: When the sampled band is cooler than the band in force, the change waits until the running interval expires.
- R6: ref_req_o is high whenever postponed_o is nonzero. An acknowledge while a refresh is owed lowers postponed_o by one. An expiry and an acknowledge in the same cycle leave it unchanged.
- R7: postponed_o saturates at POSTPONE_MAX (8). Further expiries without an acknowledge leave it at 8.
- R8: A valid sample above 105 sets over_temp_o on the next edge and selects the hot band. The next valid sample at or below 105 clears the flag.
- R9: An acknowledge while nothing is owed has no effect, and postponed_o stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| temp_i | input | TEMP_W | Signed case temperature, °C |
| temp_vld_i | input | 1 | Qualifies temp_i |
| ref_ack_i | input | 1 | Arbiter grant of one refresh |
| ref_req_o | output | 1 | Refresh owed (level) |
| postponed_o | output | PW | Count of owed refreshes |
| over_temp_o | output | 1 | Last valid sample above 105°C |

## Verification
The hardest case to reach is a hot-band sample arriving in the middle of a long cool interval, where the clamp must cut the remaining count. A cool sample arriving mid-interval is also hard, because the longer interval must not start until the current one expires. The stimulus injects single-cycle temperature samples at random offsets inside intervals, and also runs directed heat and cool steps. A per-cycle model built from the requirements tracks the expected request, owed count and flag. The cap and the acknowledge-when-idle cases come from long stretches with the acknowledge held low, and then held high.

// File: rtl/refsch_pkg.sv
package refsch_pkg;
  typedef enum logic [1:0] {
    BAND_COOL = 2'd0,
    BAND_WARM = 2'd1,
    BAND_HOT  = 2'd2
  } band_e;

  localparam int WARM_ABOVE  = 85;
  localparam int HOT_ABOVE   = 95;
  localparam int LIMIT_ABOVE = 105;
endpackage

// File: rtl/temp_classifier.sv
module temp_classifier
  import refsch_pkg::*;
#(
  parameter int TW = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic signed [TW-1:0] temp_i,
  input  logic                 vld_i,
  output band_e                band_o,
  output logic                 over_o
);
  band_e band_d;
  int    t;

  always_comb begin
    t = int'(temp_i);
    if (t > HOT_ABOVE)       band_d = BAND_HOT;
    else if (t > WARM_ABOVE) band_d = BAND_WARM;
    else                     band_d = BAND_COOL;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      band_o <= BAND_COOL;
      over_o <= 1'b0;
    end else if (vld_i) begin
      band_o <= band_d;
      over_o <= (t > LIMIT_ABOVE);
    end
  end
endmodule

// File: rtl/interval_timer.sv
module interval_timer
  import refsch_pkg::*;
#(
  parameter int IVL0 = 976,
  parameter int CW   = 10
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  band_e tgt_i,
  output logic  tick_o,
  output band_e act_o
);
  localparam int NB = 3;

  logic [CW-1:0] len_m1 [NB];
  logic [CW-1:0] cnt_q, dec, tgt_len;

  // band k runs IVL0 >> k cycles
  for (genvar k = 0; k < NB; k++) begin : g_len
    assign len_m1[k] = CW'((IVL0 >> k) - 1);
  end

  assign tick_o  = (cnt_q == '0);
  assign dec     = cnt_q - 1'b1;
  assign tgt_len = len_m1[tgt_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= len_m1[0];
      act_o <= BAND_COOL;
    end else if (tick_o) begin
      cnt_q <= tgt_len;
      act_o <= tgt_i;
    end else if (tgt_i > act_o) begin
      // heating: shorten the running interval now
      cnt_q <= (dec < tgt_len) ? dec : tgt_len;
      act_o <= tgt_i;
    end else begin
      cnt_q <= dec;
    end
  end
endmodule

// File: rtl/owed_counter.sv
module owed_counter #(
  parameter int CAP = 8,
  parameter int PW  = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          ack_i,
  output logic          req_o,
  output logic [PW-1:0] cnt_o
);
  logic grant;

  assign req_o = (cnt_o != '0);
  assign grant = ack_i && req_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o <= '0;
    end else begin
      unique case ({tick_i, grant})
        2'b10:   if (cnt_o < PW'(CAP)) cnt_o <= cnt_o + 1'b1;
        2'b01:   cnt_o <= cnt_o - 1'b1;
        default: cnt_o <= cnt_o;
      endcase
    end
  end
endmodule

// File: rtl/refresh_scheduler.sv
module refresh_scheduler
  import refsch_pkg::*;
#(
  parameter int CYC_PER_US   = 125,
  parameter int TEMP_W       = 8,
  parameter int POSTPONE_MAX = 8,
  localparam int IVL0 = CYC_PER_US * 15625 / 2000,
  localparam int CW   = $clog2(IVL0),
  localparam int PW   = $clog2(POSTPONE_MAX + 1)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic signed [TEMP_W-1:0] temp_i,
  input  logic                     temp_vld_i,
  input  logic                     ref_ack_i,
  output logic                     ref_req_o,
  output logic [PW-1:0]            postponed_o,
  output logic                     over_temp_o
);
  band_e tgt_band, act_band;
  logic  tick_w;

  temp_classifier #(.TW(TEMP_W)) u_cls (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .temp_i (temp_i),
    .vld_i  (temp_vld_i),
    .band_o (tgt_band),
    .over_o (over_temp_o)
  );

  interval_timer #(.IVL0(IVL0), .CW(CW)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tgt_i  (tgt_band),
    .tick_o (tick_w),
    .act_o  (act_band)
  );

  owed_counter #(.CAP(POSTPONE_MAX), .PW(PW)) u_owed (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_w),
    .ack_i  (ref_ack_i),
    .req_o  (ref_req_o),
    .cnt_o  (postponed_o)
  );
endmodule

// File: rtl/refresh_scheduler_chk.sv
module refresh_scheduler_chk
  import refsch_pkg::*;
#(
  parameter int PW  = 4,
  parameter int MAX = 8,
  parameter int TW  = 8
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 tick_i,
  input logic                 ack_i,
  input logic                 req_i,
  input logic [PW-1:0]        pend_i,
  input band_e                tgt_i,
  input band_e                act_i,
  input logic signed [TW-1:0] temp_i,
  input logic                 vld_i,
  input logic                 over_i
);
  p_expiry_adds_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !ack_i && pend_i < PW'(MAX)) |=> pend_i == $past(pend_i) + 1'b1);

  p_heat_now_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tgt_i > act_i) |=> act_i == $past(tgt_i));

  p_cool_waits_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && tgt_i < act_i) |=> act_i == $past(act_i));

  p_req_held_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !ack_i) |=> req_i);

  p_grant_dec_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && ack_i && !tick_i) |=> pend_i == $past(pend_i) - 1'b1);

  p_no_overflow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_i <= PW'(MAX));

  p_over_flag_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && int'(temp_i) > LIMIT_ABOVE) |=> (over_i && tgt_i == BAND_HOT));

  p_idle_ack_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_i && !tick_i) |=> pend_i == '0);
endmodule

bind refresh_scheduler refresh_scheduler_chk #(
  .PW(PW), .MAX(POSTPONE_MAX), .TW(TEMP_W)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .tick_i (tick_w),
  .ack_i  (ref_ack_i),
  .req_i  (ref_req_o),
  .pend_i (postponed_o),
  .tgt_i  (tgt_band),
  .act_i  (act_band),
  .temp_i (temp_i),
  .vld_i  (temp_vld_i),
  .over_i (over_temp_o)
);

// File: tb/refresh_scheduler_tb_top.sv
module refresh_scheduler_tb_top;
  localparam int CPU  = 8;
  localparam int IVL0 = CPU * 15625 / 2000;  // 62
  localparam int PW   = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic signed [7:0] temp = 8'sd25;
  logic vld = 1'b0, ack = 1'b0;
  logic req, over;
  logic [PW-1:0] pend;

  int n_chk = 0, n_bad = 0;
  bit cmp_en = 1'b0;
  string phase = "R1";

  always #4 clk = ~clk;  // 125 MHz

  refresh_scheduler #(.CYC_PER_US(CPU)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .temp_i(temp), .temp_vld_i(vld),
    .ref_ack_i(ack), .ref_req_o(req), .postponed_o(pend), .over_temp_o(over)
  );

  function automatic int band_of(int t);
    if (t > 95) return 2;
    if (t > 85) return 1;
    return 0;
  endfunction

  function automatic int ivl_of(int b);
    return IVL0 >> b;
  endfunction

  // reference model built from the requirements
  int m_tgt, m_act, m_cnt, m_owed;
  bit m_err;
  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_tgt <= 0; m_act <= 0; m_cnt <= IVL0 - 1; m_owed <= 0; m_err <= 0;
    end else begin
      automatic bit expire = (m_cnt == 0);
      automatic int o = m_owed;
      if (vld) begin
        m_tgt <= band_of(int'(temp));
        m_err <= int'(temp) > 105;
      end
      if (expire) begin
        m_act <= m_tgt; m_cnt <= ivl_of(m_tgt) - 1;
      end else if (m_tgt > m_act) begin
        m_act <= m_tgt;
        m_cnt <= (m_cnt - 1 < ivl_of(m_tgt) - 1) ? m_cnt - 1 : ivl_of(m_tgt) - 1;
      end else begin
        m_cnt <= m_cnt - 1;
      end
      if (ack && o != 0) o = o - 1;
      if (expire) o = o + 1;
      if (o > 8) o = 8;
      m_owed <= o;
    end
  end

  task automatic check(string tag, int act_v, int exp_v, string what);
    n_chk++;
    if (act_v != exp_v) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act_v, exp_v, $time);
    end
  endtask

  always @(negedge clk) if (cmp_en && rst_ni) begin
    check(phase, int'(pend), m_owed, "postponed");
    check(phase, int'(req), int'(m_owed != 0), "request");
    check(phase, int'(over), int'(m_err), "over_temp");
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic sample(int t);
    @(negedge clk); temp = 8'(t); vld = 1'b1;
    @(negedge clk); vld = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1", int'(req), 0, "reset request");
    check("R1", int'(pend), 0, "reset postponed");
    check("R1", int'(over), 0, "reset over_temp");
    rst_ni = 1'b1;
    cmp_en = 1'b1;
    repeat (IVL0 - 1) @(posedge clk);
    @(negedge clk);
    check("R1", int'(req), 0, "no request before first interval");
    @(negedge clk);
    check("R3", int'(req), 1, "request after first cool interval");
    check("R3", int'(pend), 1, "one owed after first interval");

    phase = "R7";
    repeat (10 * IVL0) @(negedge clk);
    check("R7", int'(pend), 8, "saturated owed count");

    phase = "R6";
    ack = 1'b1;
    for (int i = 0; i < 40 && req; i++) @(negedge clk);
    check("R6", int'(pend), 0, "drained by acknowledges");

    phase = "R9";
    repeat (3 * IVL0) @(negedge clk);
    check("R9", int'(pend > 1), 0, "idle ack leaves nothing owed");
    ack = 1'b0;

    phase = "R4";
    repeat (IVL0 / 3) @(negedge clk);
    sample(90);
    repeat (2 * IVL0) @(negedge clk);
    sample(100);
    repeat (2 * IVL0) @(negedge clk);

    phase = "R5";
    ack = 1'b1;
    repeat (5) @(negedge clk);
    sample(20);
    repeat (3 * IVL0) @(negedge clk);
    ack = 1'b0;

    phase = "R8";
    sample(110);
    check("R8", int'(over), 1, "flag after 110C");
    repeat (IVL0) @(negedge clk);
    sample(50);
    check("R8", int'(over), 0, "flag cleared by 50C");

    phase = "R2 R3";
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      vld  = ($urandom_range(0, 40) == 0);
      temp = 8'($urandom_range(0, 160) - 40);
      ack  = ($urandom_range(0, 9) < 3);
    end
    vld = 1'b0; ack = 1'b0;
    repeat (4) @(negedge clk);
    summary();
  end
endmodule